// File: doc/BRIEF.md
# Paged Control Register File

This block is the control register store of a multi-channel signal-processing chip. A processor reaches it through a 5-bit address bus with a chip select and a write strobe. The sixteen lower addresses hold global registers. The sixteen upper addresses form a window into a much larger paged space, and the page shown in that window is the 8-bit value held in global register 2. Every stored value is also driven onto wide output buses so that the processing blocks can use it directly.

The paged space splits into four identical per-channel banks and two shared banks. Each per-channel bank covers a 32-page range, and only the first `CH_DEPTH` pages of that range hold storage. The shared banks sit at two page pairs in the upper half of the page space. Stored contents are kept across every functional reset. Only a dedicated power-on-init input loads the global defaults. The functional reset input combines with a software reset bit in global register 0 to drive a reset output for the consumers.

Top module: `paged_regfile`

## Requirements
- R1: Addresses 0x00 to 0x0F select the global registers. Addresses 0x10 to 0x1F select register `addr[3:0]` of the page held in bits [7:0] of global register 2.
- R2: A write takes effect on the rising clock edge where `cs` and `we` are both high. With `cs` low nothing is written. `rdata` follows `addr` and the current page combinationally.
- R3: A read of global address 0x02 returns the page in bits [7:0] and the constant `REV` (default 0x5A) in bits [15:8]. A write cannot change the revision field.
- R4: For a page with bit 7 clear, bits [6:5] choose channel bank 0 to 3 and bits [4:0] give the page within that bank. Pages 0x80 and 0x81 select pages 0 and 1 of shared bank 0. Pages 0xA0 and 0xA1 select pages 0 and 1 of shared bank 1. All banks are independent storage.
- R5: A paged access to an unmapped page is ignored for writes and reads zero. Unmapped pages are channel pages whose in-bank index is `CH_DEPTH` (default 2) or higher, and every page with bit 7 set other than the four shared pages.
- R6: A write to the page register changes the window for the very next access.
- R7: While `por_n` is low, global register 0 is set to `R0_DEFAULT` (0x0003) and all other global registers are cleared, including the page. Writes are ignored while `por_n` is low and on the first two rising edges after its release. Paged contents are untouched.
- R8: `rst_n` changes no stored value. `core_rst_n` is low whenever `rst_n` is low or bit 0 of global register 0 is set.
- R9: `glob_o` carries global register i at bits [16i+15:16i], and register 2 appears as it reads. `ch_o` carries channel c, page p, register r at word index (c*CH_DEPTH+p)*16+r. `sh_o` carries shared bank s, page p, register r at word index (s*SH_DEPTH+p)*16+r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on init, active low; loads global defaults |
| rst_n | input | 1 | Functional reset, active low; does not touch storage |
| cs | input | 1 | Chip select |
| we | input | 1 | Write strobe |
| addr | input | 5 | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data |
| page_o | output | 8 | Current page |
| glob_o | output | 16*DW | All global registers |
| ch_o | output | 4*CH_DEPTH*16*DW | All per-channel bank registers |
| sh_o | output | 2*SH_DEPTH*16*DW | All shared bank registers |
| core_rst_n | output | 1 | Combined reset for the consumers, active low |

## Verification
Every mapped register is first filled with distinct values through a page-by-page sweep. A full read-back then separates correct bank and page selection from aliasing between channels, between pages of a bank, and between channel and shared storage. Random sequences mix page changes over mapped and unmapped pages with writes and reads at random addresses. These expose a stale page or a page change that takes effect a cycle late, and show whether writes to unmapped pages leak into real storage. Directed cases cover the read-only revision field, writes with the select low, the write lockout around power-on init, and a functional reset pulse, each followed by a full scan that shows the storage was preserved.

// File: rtl/pr_pkg.sv
package pr_pkg;

  localparam int ADDR_W        = 5;
  localparam int REGS_PER_PAGE = 16;
  localparam int PAGE_W        = 8;
  localparam int NUM_CH        = 4;
  localparam int NUM_SH        = 2;
  localparam logic [3:0] PAGE_REG = 4'd2;

  typedef struct packed {
    logic       hit;
    logic       shared;
    logic [1:0] ch;
    logic       sh_sel;
    logic [4:0] lpage;
  } pg_dec_t;

  // Page value to bank selection
  function automatic pg_dec_t decode_page(input logic [PAGE_W-1:0] pg,
                                          input int ch_depth,
                                          input int sh_depth);
    pg_dec_t d;
    d        = '0;
    d.ch     = pg[6:5];
    d.sh_sel = pg[5];
    if (!pg[7]) begin
      d.lpage = pg[4:0];
      d.hit   = (int'(pg[4:0]) < ch_depth);
    end else if (!pg[6] && (pg[4:1] == 4'd0)) begin
      d.shared = 1'b1;
      d.lpage  = {4'd0, pg[0]};
      d.hit    = (int'(pg[0]) < sh_depth);
    end
    return d;
  endfunction

endpackage

// File: rtl/pr_por_sync.sv
module pr_por_sync (
  input  logic clk,
  input  logic por_n,
  output logic ready
);
  logic [1:0] stage_q;
  logic [1:0] stage_nxt;

  assign stage_nxt = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) stage_q <= '0;
    else        stage_q <= stage_nxt;
  end

  assign ready = stage_q[1];
endmodule

// File: rtl/pr_globals.sv
module pr_globals #(
  parameter int            DW         = 16,
  parameter logic [7:0]    REV        = 8'h5A,
  parameter logic [DW-1:0] R0_DEFAULT = 16'h0003
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_ok,
  input  logic             wr_en,
  input  logic [3:0]       ra,
  input  logic [DW-1:0]    wd,
  output logic [DW-1:0]    rd,
  output logic [7:0]       page,
  output logic [16*DW-1:0] flat
);
  import pr_pkg::*;

  logic [DW-1:0] greg     [REGS_PER_PAGE];
  logic [DW-1:0] greg_nxt [REGS_PER_PAGE];
  logic [DW-1:0] page_view;

  always_comb begin
    for (int i = 0; i < REGS_PER_PAGE; i++) greg_nxt[i] = greg[i];
    if (wr_en && wr_ok) begin
      if (ra == PAGE_REG) greg_nxt[ra] = {{(DW-8){1'b0}}, wd[7:0]};
      else                greg_nxt[ra] = wd;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < REGS_PER_PAGE; i++)
        greg[i] <= (i == 0) ? R0_DEFAULT : '0;
    end else begin
      for (int i = 0; i < REGS_PER_PAGE; i++) greg[i] <= greg_nxt[i];
    end
  end

  always_comb begin
    page_view            = '0;
    page_view[7:0]       = greg[PAGE_REG][7:0];
    page_view[DW-1 -: 8] = REV;
  end

  assign page = greg[PAGE_REG][7:0];
  assign rd   = (ra == PAGE_REG) ? page_view : greg[ra];

  for (genvar g = 0; g < REGS_PER_PAGE; g++) begin : g_flat
    if (g == int'(PAGE_REG)) begin : g_pg
      assign flat[g*DW +: DW] = page_view;
    end else begin : g_plain
      assign flat[g*DW +: DW] = greg[g];
    end
  end
endmodule

// File: rtl/pr_bank.sv
module pr_bank #(
  parameter int DW  = 16,
  parameter int NPG = 2
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [4:0]          lpage,
  input  logic [3:0]          ra,
  input  logic [DW-1:0]       wd,
  output logic [DW-1:0]       rd,
  output logic [NPG*16*DW-1:0] flat
);
  localparam int LPW   = (NPG > 1) ? $clog2(NPG) : 1;
  localparam int DEPTH = NPG * 16;
  localparam int IW    = LPW + 4;

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] idx;
  logic          in_range;
  logic          wen;

  assign in_range = (int'(lpage) < NPG);
  assign idx      = {lpage[LPW-1:0], ra};

  always_comb begin
    wen = wr_en && in_range;
  end

  always_ff @(posedge clk) begin
    if (wen) mem[idx] <= wd;
  end

  assign rd = in_range ? mem[idx] : '0;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign flat[g*DW +: DW] = mem[g];
  end
endmodule

// File: rtl/paged_regfile.sv
module paged_regfile #(
  parameter int            DW         = 16,
  parameter int            CH_DEPTH   = 2,
  parameter int            SH_DEPTH   = 2,
  parameter logic [7:0]    REV        = 8'h5A,
  parameter logic [DW-1:0] R0_DEFAULT = 16'h0003
) (
  input  logic                           clk,
  input  logic                           por_n,
  input  logic                           rst_n,
  input  logic                           cs,
  input  logic                           we,
  input  logic [4:0]                     addr,
  input  logic [DW-1:0]                  wdata,
  output logic [DW-1:0]                  rdata,
  output logic [7:0]                     page_o,
  output logic [16*DW-1:0]               glob_o,
  output logic [4*CH_DEPTH*16*DW-1:0]    ch_o,
  output logic [2*SH_DEPTH*16*DW-1:0]    sh_o,
  output logic                           core_rst_n
);
  import pr_pkg::*;

  localparam int CH_FLAT = CH_DEPTH * REGS_PER_PAGE * DW;
  localparam int SH_FLAT = SH_DEPTH * REGS_PER_PAGE * DW;

  logic          por_ready;
  logic          wr_req;
  logic          paged_wr;
  logic [DW-1:0] glob_rd;
  logic [DW-1:0] ch_rd [NUM_CH];
  logic [DW-1:0] sh_rd [NUM_SH];
  pg_dec_t       dec;

  assign wr_req = cs && we;
  assign dec    = decode_page(page_o, CH_DEPTH, SH_DEPTH);

  pr_por_sync u_por (
    .clk   (clk),
    .por_n (por_n),
    .ready (por_ready)
  );

  pr_globals #(.DW(DW), .REV(REV), .R0_DEFAULT(R0_DEFAULT)) u_glob (
    .clk   (clk),
    .por_n (por_n),
    .wr_ok (por_ready),
    .wr_en (wr_req && !addr[4]),
    .ra    (addr[3:0]),
    .wd    (wdata),
    .rd    (glob_rd),
    .page  (page_o),
    .flat  (glob_o)
  );

  assign paged_wr = wr_req && addr[4] && por_ready && dec.hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pr_bank #(.DW(DW), .NPG(CH_DEPTH)) u_bank (
      .clk   (clk),
      .wr_en (paged_wr && !dec.shared && (dec.ch == 2'(c))),
      .lpage (dec.lpage),
      .ra    (addr[3:0]),
      .wd    (wdata),
      .rd    (ch_rd[c]),
      .flat  (ch_o[c*CH_FLAT +: CH_FLAT])
    );
  end

  for (genvar s = 0; s < NUM_SH; s++) begin : g_sh
    pr_bank #(.DW(DW), .NPG(SH_DEPTH)) u_bank (
      .clk   (clk),
      .wr_en (paged_wr && dec.shared && (dec.sh_sel == 1'(s))),
      .lpage (dec.lpage),
      .ra    (addr[3:0]),
      .wd    (wdata),
      .rd    (sh_rd[s]),
      .flat  (sh_o[s*SH_FLAT +: SH_FLAT])
    );
  end

  always_comb begin
    if (!addr[4])       rdata = glob_rd;
    else if (!dec.hit)  rdata = '0;
    else if (dec.shared) rdata = sh_rd[dec.sh_sel];
    else                rdata = ch_rd[dec.ch];
  end

  assign core_rst_n = rst_n && !glob_o[0];
endmodule

// File: rtl/pr_check.sv
module pr_check #(
  parameter int            DW         = 16,
  parameter int            CH_DEPTH   = 2,
  parameter int            SH_DEPTH   = 2,
  parameter logic [7:0]    REV        = 8'h5A,
  parameter logic [DW-1:0] R0_DEFAULT = 16'h0003
) (
  input logic             clk,
  input logic             por_n,
  input logic             rst_n,
  input logic             por_ready,
  input logic             cs,
  input logic             we,
  input logic [4:0]       addr,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    rdata,
  input logic [7:0]       page_o,
  input logic [16*DW-1:0] glob_o,
  input logic             core_rst_n
);
  logic mapped_pg;

  always_comb begin
    if (!page_o[7])
      mapped_pg = (int'(page_o[4:0]) < CH_DEPTH);
    else
      mapped_pg = (page_o[6:5] inside {2'b00, 2'b01}) && !page_o[6] &&
                  (page_o[4:1] == 4'd0) && (int'(page_o[0]) < SH_DEPTH);
  end

  AST_PAGE_NEXT_ACCESS: assert property (@(posedge clk) disable iff (!por_n)
    (cs && we && addr == 5'h02 && por_ready) |=> (page_o == $past(wdata[7:0]))); // R6

  AST_REV_READ_ONLY: assert property (@(posedge clk) disable iff (!por_n)
    (addr == 5'h02) |-> (rdata[DW-1 -: 8] == REV)); // R3

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    (addr[4] && !mapped_pg) |-> (rdata == '0)); // R5

  AST_GLOB_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    !(cs && we && por_ready) |=> $stable(glob_o)); // R8

  AST_CORE_RST_LOW: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |-> !core_rst_n); // R8

  AST_POR_DEFAULTS: assert property (@(posedge clk)
    $rose(por_n) |-> (glob_o[DW-1:0] == R0_DEFAULT) &&
                     (glob_o[4*DW-1:3*DW] == '0) && (page_o == 8'h00)); // R7
endmodule

bind paged_regfile pr_check #(
  .DW(DW), .CH_DEPTH(CH_DEPTH), .SH_DEPTH(SH_DEPTH), .REV(REV), .R0_DEFAULT(R0_DEFAULT)
) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .rst_n      (rst_n),
  .por_ready  (por_ready),
  .cs         (cs),
  .we         (we),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .page_o     (page_o),
  .glob_o     (glob_o),
  .core_rst_n (core_rst_n)
);

// File: tb/tb_paged_regfile.sv
module tb_paged_regfile;
  localparam int DW  = 16;
  localparam int CHD = 2;
  localparam int SHD = 2;
  localparam logic [7:0] REV = 8'h5A;

  logic clk = 1'b0;
  logic por_n, rst_n, cs, we;
  logic [4:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic [7:0] page_o;
  logic [16*DW-1:0] glob_o;
  logic [4*CHD*16*DW-1:0] ch_o;
  logic [2*SHD*16*DW-1:0] sh_o;
  logic core_rst_n;

  int checks = 0;
  int fails  = 0;

  logic [15:0] mg [16];
  logic [15:0] mc [4][CHD][16];
  logic [15:0] ms [2][SHD][16];
  logic [7:0]  mpage;

  paged_regfile dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .page_o(page_o), .glob_o(glob_o),
    .ch_o(ch_o), .sh_o(sh_o), .core_rst_n(core_rst_n)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_por();
    for (int i = 0; i < 16; i++) mg[i] = 16'h0;
    mg[0] = 16'h0003;
    mpage = 8'h00;
  endfunction

  function automatic logic [15:0] exp_rd(input logic [4:0] a);
    if (!a[4]) return (a[3:0] == 4'd2) ? {REV, mpage} : mg[a[3:0]];
    if (!mpage[7]) return (int'(mpage[4:0]) < CHD) ? mc[mpage[6:5]][mpage[0]][a[3:0]] : 16'h0;
    if (mpage[7:5] inside {3'b100, 3'b101} && mpage[4:1] == 4'd0) return ms[mpage[5]][mpage[0]][a[3:0]];
    return 16'h0;
  endfunction

  function automatic void model_wr(input logic [4:0] a, input logic [15:0] d);
    if (!a[4]) begin
      mg[a[3:0]] = d;
      if (a[3:0] == 4'd2) mpage = d[7:0];
    end else if (!mpage[7]) begin
      if (int'(mpage[4:0]) < CHD) mc[mpage[6:5]][mpage[0]][a[3:0]] = d;
    end else if (mpage[7:5] inside {3'b100, 3'b101} && mpage[4:1] == 4'd0) begin
      ms[mpage[5]][mpage[0]][a[3:0]] = d;
    end
  endfunction

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    cs = 1'b0; we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(input logic [4:0] a, input string req);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    #1;
    chk(rdata === exp_rd(a), req, rdata, exp_rd(a));
    cs = 1'b0;
  endtask

  task automatic chk_core(input string req);
    logic exp;
    exp = rst_n & ~mg[0][0];
    chk(core_rst_n === exp, req, {15'h0, core_rst_n}, {15'h0, exp});
  endtask

  task automatic scan_all(input string req);
    for (int r = 0; r < 16; r++) rd(5'(r), req);
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < CHD; p++) begin
        wr(5'h02, {8'h00, 3'(c), 5'(p)});
        for (int r = 0; r < 16; r++) rd(5'(16 + r), req);
      end
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < SHD; p++) begin
        wr(5'h02, {8'h00, 2'b10, 1'(s), 5'(p)});
        for (int r = 0; r < 16; r++) rd(5'(16 + r), req);
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] pg_list [12];
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    pg_list = '{8'h00, 8'h01, 8'h21, 8'h40, 8'h61, 8'h80, 8'hA1, 8'h81,
                8'h05, 8'h82, 8'hC0, 8'h7F};
    por_n = 1'b0; rst_n = 1'b1; cs = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    model_por();
    repeat (3) @(posedge clk);
    @(negedge clk); por_n = 1'b1;
    repeat (4) @(posedge clk);

    // Reset state: R7 defaults, R3 revision, R8 soft reset bit
    rd(5'h00, "R7 reg0 default");
    rd(5'h03, "R7 reg3 cleared");
    rd(5'h02, "R3 page/revision after init");
    chk_core("R8 core reset from soft bit");

    // Fill every mapped register: R1, R4
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < CHD; p++) begin
        wr(5'h02, {8'h00, 3'(c), 5'(p)});
        for (int r = 0; r < 16; r++) wr(5'(16 + r), 16'($urandom));
      end
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < SHD; p++) begin
        wr(5'h02, {8'h00, 2'b10, 1'(s), 5'(p)});
        for (int r = 0; r < 16; r++) wr(5'(16 + r), 16'($urandom));
      end
    for (int r = 0; r < 16; r++) if (r != 2) wr(5'(r), 16'($urandom));
    wr(5'h00, 16'h0000);
    scan_all("R4 bank separation");
    chk_core("R8 soft bit cleared");

    // R3 revision is read-only
    wr(5'h02, 16'hFF21);
    rd(5'h02, "R3 revision not writable");

    // R6 page switch visible on next access
    wr(5'h02, 16'h0041);
    wr(5'h17, 16'hBEEF);
    rd(5'h17, "R6 write after page change");
    wr(5'h02, 16'h0040);
    rd(5'h17, "R6 other page unaffected");

    // R5 unmapped pages
    wr(5'h02, 16'h0022); wr(5'h13, 16'h1234); rd(5'h13, "R5 channel page beyond depth");
    wr(5'h02, 16'h0082); wr(5'h1F, 16'h4321); rd(5'h1F, "R5 shared gap page");
    wr(5'h02, 16'h00E0); wr(5'h10, 16'h7777); rd(5'h10, "R5 upper unmapped page");

    // R2 write with cs low ignored
    @(negedge clk); cs = 1'b0; we = 1'b1; addr = 5'h05; wdata = 16'hDEAD;
    @(posedge clk); #1; we = 1'b0;
    rd(5'h05, "R2 cs low write ignored");

    // R9 output buses
    chk(ch_o[((1*CHD+1)*16+7)*DW +: DW] === mc[1][1][7], "R9 ch_o layout",
        ch_o[((1*CHD+1)*16+7)*DW +: DW], mc[1][1][7]);
    chk(sh_o[((1*SHD+0)*16+3)*DW +: DW] === ms[1][0][3], "R9 sh_o layout",
        sh_o[((1*SHD+0)*16+3)*DW +: DW], ms[1][0][3]);
    chk(glob_o[2*DW +: DW] === {REV, mpage}, "R9 glob_o page word",
        glob_o[2*DW +: DW], {REV, mpage});
    chk(glob_o[9*DW +: DW] === mg[9], "R9 glob_o reg9", glob_o[9*DW +: DW], mg[9]);

    // Random mix: R1, R2, R4, R5, R6
    for (int i = 0; i < 600; i++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      if (op < 3)      wr(5'h02, {8'h00, pg_list[$urandom_range(0, 11)]});
      else if (op < 6) wr(5'(16 + $urandom_range(0, 15)), 16'($urandom));
      else if (op < 7) wr(5'(4 + $urandom_range(0, 11)), 16'($urandom));
      else             rd(5'($urandom_range(0, 31)), "R1 random read");
    end
    scan_all("R5 no leak from random traffic");

    // R8 functional reset keeps storage
    wr(5'h00, 16'h00A4);
    @(negedge clk); rst_n = 1'b0;
    #1 chk_core("R8 core reset follows rst_n");
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 chk_core("R8 core reset released");
    scan_all("R8 storage kept over rst_n");

    // R7 init again: writes locked out during and just after
    wr(5'h02, 16'h0061);
    @(negedge clk); por_n = 1'b0;
    cs = 1'b1; we = 1'b1; addr = 5'h03; wdata = 16'h00FF;
    @(posedge clk); #1;
    @(negedge clk); por_n = 1'b1; addr = 5'h04; wdata = 16'h1111;
    @(posedge clk); #1;
    @(negedge clk); addr = 5'h05; wdata = 16'h2222;
    @(posedge clk); #1;
    cs = 1'b0; we = 1'b0;
    model_por();
    rd(5'h03, "R7 write ignored while init low");
    rd(5'h04, "R7 write ignored first edge");
    rd(5'h05, "R7 write ignored second edge");
    rd(5'h02, "R7 page cleared");
    chk_core("R7 soft bit default");
    wr(5'h06, 16'h3333);
    rd(5'h06, "R7 write accepted after lockout");
    scan_all("R7 paged contents kept");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule